// File: doc/BRIEF.md
# DDR2 Read/Write Data Window Timer

This block runs beside the command path of a DDR2 memory controller. It is told each time a Read or Write command is put on the command bus. From the programmed CAS latency, additive latency and burst length it works out the clock cycles in which read data must be captured or write data driven. It raises a read-capture enable or a write-drive enable for each of those cycles, together with the index of the first of the two data beats that fall into that clock.

The read delay is the additive latency plus the CAS latency. The write delay is one clock less. Pending windows sit in a slot chain that advances one position per clock. A command is written into the chain at its delay offset, so several commands can be in flight at once. The chain is deep enough for the longest delay plus the longest burst.

Settings are loaded through a single strobe. A setting is taken only while nothing is in flight. A setting with a value outside the supported sets is refused and flagged.

Top module: `ddr2_lat_pipe`

## Requirements
- R1: After reset the settings are CAS latency 3, additive latency 0 and burst length 4. `rd_en`, `wr_en`, `busy` and `cfg_err` are low and `beat_idx` is 0.
- R2: A read command sampled at clock edge k drives `rd_en` high from edge k+RL, where RL = AL + CL, for BL/2 consecutive clocks.
- R3: A write command sampled at edge k drives `wr_en` high from edge k+RL-1 for BL/2 consecutive clocks.
- R4: While an enable is high, `beat_idx` gives the first beat of the current clock: 0, 2 for a burst of 4 and 0, 2, 4, 6 for a burst of 8. It is 0 while both enables are low.
- R5: The `cfg_bl` value 4 gives a 2-clock window and the value 8 gives a 4-clock window.
- R6: A second command issued before an earlier command's window has begun produces its own window at its own delay. The earlier window is not disturbed when the two windows do not share a clock.
- R7: A `cfg_wr` whose `cfg_cl` is outside 3..7, whose `cfg_al` is outside 0..6, or whose `cfg_bl` is neither 4 nor 8 raises `cfg_err` for the next clock and changes no setting. `cfg_err` is low otherwise.
- R8: A legal `cfg_wr` presented while `busy` is high is ignored. Later commands keep the previous timing.
- R9: A legal `cfg_wr` presented while `busy` is low is taken at that edge. A command sampled at the same edge still uses the old settings, and later commands use the new ones.
- R10: `busy` is high from the edge after a command until the last clock of every pending window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A Read or Write command is issued this cycle |
| cmd_is_wr | input | 1 | 1 = Write, 0 = Read |
| cfg_wr | input | 1 | Load strobe for the three settings |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_al | input | 3 | Additive latency in clocks |
| cfg_bl | input | 4 | Burst length in beats |
| rd_en | output | 1 | Read-data capture window |
| wr_en | output | 1 | Write-data drive window |
| beat_idx | output | 3 | First beat index carried in this clock |
| busy | output | 1 | At least one window is still pending |
| cfg_err | output | 1 | Previous `cfg_wr` carried an unsupported value |

## Verification
The hardest situation to reach is several windows in flight at once, with different kinds and offsets, while the settings are being touched. The stimulus issues a second command a few clocks after the first, before the first window has started. It pairs read after read and write after read at settings where the two windows come out back to back. A separate scenario writes new settings while a burst is pending, and another issues a command in the same cycle as a settings load. In both, a later command then shows which timing the block is using.

// File: rtl/ddr2_lat_pkg.sv
package ddr2_lat_pkg;

  localparam int CL_MIN = 3;
  localparam int CL_MAX = 7;
  localparam int AL_MAX = 6;
  localparam int BL_MAX = 8;
  localparam int BEAT_W = $clog2(BL_MAX);
  localparam int SLOTS  = AL_MAX + CL_MAX + BL_MAX / 2;

  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [BEAT_W-1:0] beat;
  } slot_t;

  function automatic bit cl_legal(input int unsigned v);
    return (v >= CL_MIN) && (v <= CL_MAX);
  endfunction

  function automatic bit al_legal(input int unsigned v);
    return v <= AL_MAX;
  endfunction

  function automatic bit bl_legal(input int unsigned v);
    return (v == 4) || (v == 8);
  endfunction

  function automatic int unsigned rd_delay(input int unsigned cl, input int unsigned al);
    return cl + al;
  endfunction

  function automatic int unsigned wr_delay(input int unsigned cl, input int unsigned al);
    return cl + al - 1;
  endfunction

  function automatic int unsigned burst_clocks(input int unsigned bl);
    return bl / 2;
  endfunction

endpackage

// File: rtl/ddr2_lat_cfg.sv
module ddr2_lat_cfg
  import ddr2_lat_pkg::*;
#(
  parameter int CLW = 3,
  parameter int ALW = 3,
  parameter int BLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [CLW-1:0] cfg_cl,
  input  logic [ALW-1:0] cfg_al,
  input  logic [BLW-1:0] cfg_bl,
  input  logic           busy,
  output logic [CLW-1:0] act_cl,
  output logic [ALW-1:0] act_al,
  output logic [BLW-1:0] act_bl,
  output logic           cfg_ok,
  output logic           cfg_err
);

  logic cfg_take;

  always_comb begin
    cfg_ok   = cl_legal(int'(cfg_cl)) && al_legal(int'(cfg_al)) && bl_legal(int'(cfg_bl));
    cfg_take = cfg_wr && cfg_ok && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cl  <= CLW'(CL_MIN);
      act_al  <= '0;
      act_bl  <= BLW'(4);
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= cfg_wr && !cfg_ok;
      if (cfg_take) begin
        act_cl <= cfg_cl;
        act_al <= cfg_al;
        act_bl <= cfg_bl;
      end
    end
  end

endmodule

// File: rtl/ddr2_lat_slots.sv
module ddr2_lat_slots
  import ddr2_lat_pkg::*;
#(
  parameter int DEPTH = SLOTS,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins,
  input  logic          ins_wr,
  input  logic [LW-1:0] ins_lat,
  input  logic [LW-1:0] ins_span,
  output slot_t         head,
  output logic          pend
);

  slot_t q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_t       from_up;
    slot_t       nxt;
    logic [LW-1:0] idx;
    logic [LW-1:0] off;
    logic        hit;

    if (i == DEPTH - 1) begin : g_tail
      assign from_up = '0;
    end else begin : g_body
      assign from_up = q[i+1];
    end

    assign idx = LW'(i);

    always_comb begin
      off = idx - ins_lat;
      hit = ins && (idx >= ins_lat) &&
            ({1'b0, idx} < ({1'b0, ins_lat} + {1'b0, ins_span}));
      if (hit) begin
        nxt.vld  = 1'b1;
        nxt.wr   = ins_wr;
        nxt.beat = BEAT_W'({off, 1'b0});
      end else begin
        nxt = from_up;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= nxt;
    end
  end

  always_comb begin
    pend = 1'b0;
    for (int j = 0; j < DEPTH; j++) pend = pend | q[j].vld;
  end

  assign head = q[0];

endmodule

// File: rtl/ddr2_lat_pipe.sv
module ddr2_lat_pipe
  import ddr2_lat_pkg::*;
#(
  parameter int CLW   = 3,
  parameter int ALW   = 3,
  parameter int BLW   = 4,
  parameter int DEPTH = SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_wr,
  input  logic              cfg_wr,
  input  logic [CLW-1:0]    cfg_cl,
  input  logic [ALW-1:0]    cfg_al,
  input  logic [BLW-1:0]    cfg_bl,
  output logic              rd_en,
  output logic              wr_en,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              busy,
  output logic              cfg_err
);

  localparam int LW = $clog2(DEPTH + 1);

  logic [CLW-1:0] act_cl;
  logic [ALW-1:0] act_al;
  logic [BLW-1:0] act_bl;
  logic           cfg_ok;
  logic [LW-1:0]  lat_sel;
  logic [LW-1:0]  span_sel;
  slot_t          head;
  logic           pend;

  ddr2_lat_cfg #(.CLW(CLW), .ALW(ALW), .BLW(BLW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_cl  (cfg_cl),
    .cfg_al  (cfg_al),
    .cfg_bl  (cfg_bl),
    .busy    (busy),
    .act_cl  (act_cl),
    .act_al  (act_al),
    .act_bl  (act_bl),
    .cfg_ok  (cfg_ok),
    .cfg_err (cfg_err)
  );

  always_comb begin
    if (cmd_is_wr) lat_sel = LW'(wr_delay(int'(act_cl), int'(act_al)));
    else           lat_sel = LW'(rd_delay(int'(act_cl), int'(act_al)));
    span_sel = LW'(burst_clocks(int'(act_bl)));
  end

  ddr2_lat_slots #(.DEPTH(DEPTH), .LW(LW)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins      (cmd_valid),
    .ins_wr   (cmd_is_wr),
    .ins_lat  (lat_sel),
    .ins_span (span_sel),
    .head     (head),
    .pend     (pend)
  );

  assign busy     = pend;
  assign rd_en    = head.vld && !head.wr;
  assign wr_en    = head.vld && head.wr;
  assign beat_idx = head.vld ? head.beat : '0;

endmodule

// File: rtl/ddr2_lat_chk.sv
module ddr2_lat_chk
  import ddr2_lat_pkg::*;
#(
  parameter int CLW = 3,
  parameter int ALW = 3,
  parameter int BLW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cfg_wr,
  input logic [CLW-1:0]    cfg_cl,
  input logic [ALW-1:0]    cfg_al,
  input logic [BLW-1:0]    cfg_bl,
  input logic              cfg_ok,
  input logic              cfg_err,
  input logic              busy,
  input logic              rd_en,
  input logic              wr_en,
  input logic [BEAT_W-1:0] beat_idx,
  input logic [CLW-1:0]    act_cl,
  input logic [ALW-1:0]    act_al,
  input logic [BLW-1:0]    act_bl
);

  // R7
  bad_cfg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ok) |=> cfg_err);

  // R7
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !cfg_ok) |=> !cfg_err);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (busy || !cfg_ok)) |=> $stable({act_cl, act_al, act_bl}));

  // R9
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_ok && !busy) |=>
      (act_cl == $past(cfg_cl) && act_al == $past(cfg_al) && act_bl == $past(cfg_bl)));

  // R4
  beat_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && beat_idx != '0) |-> $past(rd_en || wr_en));

  // R10
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> busy);

endmodule

bind ddr2_lat_pipe ddr2_lat_chk #(.CLW(CLW), .ALW(ALW), .BLW(BLW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cfg_wr    (cfg_wr),
  .cfg_cl    (cfg_cl),
  .cfg_al    (cfg_al),
  .cfg_bl    (cfg_bl),
  .cfg_ok    (cfg_ok),
  .cfg_err   (cfg_err),
  .busy      (busy),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .beat_idx  (beat_idx),
  .act_cl    (act_cl),
  .act_al    (act_al),
  .act_bl    (act_bl)
);

// File: tb/test_ddr2_lat_pipe.sv
`timescale 1ns/1ps
module test_ddr2_lat_pipe;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_is_wr = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_cl = 3'd3;
  logic [2:0] cfg_al = 3'd0;
  logic [3:0] cfg_bl = 4'd4;
  logic       rd_en, wr_en, busy, cfg_err;
  logic [2:0] beat_idx;

  int n_chk = 0;
  int n_fail = 0;
  int m_cl = 3, m_al = 0, m_bl = 4;

  always #10 clk = ~clk;

  ddr2_lat_pipe i_ddr2_lat_pipe (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cfg_wr(cfg_wr), .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl(cfg_bl),
    .rd_en(rd_en), .wr_en(wr_en), .beat_idx(beat_idx), .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit legal(input int cl, input int al, input int bl);
    return cl >= 3 && cl <= 7 && al >= 0 && al <= 6 && (bl == 4 || bl == 8);
  endfunction

  // packed view of outputs: rd*16 + wr*8 + beat
  function automatic int outs();
    return int'(rd_en) * 16 + int'(wr_en) * 8 + int'(beat_idx);
  endfunction

  task automatic set_cfg(input int cl, input int al, input int bl, input string req);
    bit ok;
    ok = legal(cl, al, bl);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_cl = 3'(cl); cfg_al = 3'(al); cfg_bl = 4'(bl);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(cfg_err == !ok, req, int'(cfg_err), int'(!ok));
    if (ok) begin m_cl = cl; m_al = al; m_bl = bl; end
  endtask

  task automatic wait_idle();
    repeat (24) @(negedge clk);
  endtask

  // Command A now, optional command B d clocks later; optional settings
  // load presented together with A (model updated after the window).
  task automatic run_pair(input bit wa, input bit use_b, input bit wb, input int d,
                          input bit with_cfg, input int ncl, input int nal, input int nbl,
                          input string req);
    int la, lb, sp, e;
    la = m_al + m_cl - (wa ? 1 : 0);
    lb = m_al + m_cl - (wb ? 1 : 0);
    sp = m_bl / 2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = wa;
    if (with_cfg) begin
      cfg_wr = 1'b1; cfg_cl = 3'(ncl); cfg_al = 3'(nal); cfg_bl = 4'(nbl);
    end
    for (int m = 0; m < 25; m++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      e = 0;
      if (m >= la && m < la + sp) e = (wa ? 8 : 16) + (m - la) * 2;
      if (use_b && m - d >= lb && m - d < lb + sp) e = (wb ? 8 : 16) + (m - d - lb) * 2;
      chk(outs() == e, req, outs(), e);
      if (m == 0) chk(busy == 1'b1, "R10 busy after command", int'(busy), 1);
      cmd_valid = use_b && (m == d - 1);
      cmd_is_wr = wb;
    end
    chk(busy == 1'b0, "R10 busy clears", int'(busy), 0);
    if (with_cfg && legal(ncl, nal, nbl)) begin m_cl = ncl; m_al = nal; m_bl = nbl; end
  endtask

  task automatic test_reset();
    chk(outs() == 0, "R1 enables and beat", outs(), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);
    run_pair(0, 0, 0, 0, 0, 0, 0, 0, "R1 default read timing");
  endtask

  task automatic test_read();
    set_cfg(5, 2, 4, "R9 load 5/2/4");
    run_pair(0, 0, 0, 0, 0, 0, 0, 0, "R2 read RL7 BL4");
    set_cfg(7, 6, 8, "R9 load 7/6/8");
    run_pair(0, 0, 0, 0, 0, 0, 0, 0, "R2 R5 read RL13 BL8");
  endtask

  task automatic test_write();
    set_cfg(4, 0, 8, "R9 load 4/0/8");
    run_pair(1, 0, 0, 0, 0, 0, 0, 0, "R3 R5 write WL3 BL8");
    set_cfg(3, 0, 4, "R9 load 3/0/4");
    run_pair(1, 0, 0, 0, 0, 0, 0, 0, "R3 R4 write WL2 BL4");
  endtask

  task automatic test_overlap();
    set_cfg(6, 3, 8, "R9 load 6/3/8");
    run_pair(0, 1, 0, 4, 0, 0, 0, 0, "R6 read then read");
    run_pair(0, 1, 1, 5, 0, 0, 0, 0, "R6 read then write");
    set_cfg(3, 1, 4, "R9 load 3/1/4");
    run_pair(0, 1, 0, 2, 0, 0, 0, 0, "R6 R4 back to back BL4");
  endtask

  task automatic test_illegal();
    set_cfg(5, 1, 8, "R9 load 5/1/8");
    set_cfg(2, 0, 4, "R7 CL 2 refused");
    set_cfg(3, 7, 4, "R7 AL 7 refused");
    set_cfg(3, 0, 6, "R7 BL 6 refused");
    set_cfg(0, 0, 0, "R7 all zero refused");
    run_pair(0, 0, 0, 0, 0, 0, 0, 0, "R7 timing kept after refusal");
  endtask

  task automatic test_busy_ignore();
    set_cfg(4, 1, 4, "R9 load 4/1/4");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_wr = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy while pending", int'(busy), 1);
    cfg_wr = 1'b1; cfg_cl = 3'd7; cfg_al = 3'd6; cfg_bl = 4'd8;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(cfg_err == 1'b0, "R8 no flag for legal busy load", int'(cfg_err), 0);
    wait_idle();
    run_pair(0, 0, 0, 0, 0, 0, 0, 0, "R8 busy load ignored");
  endtask

  task automatic test_same_cycle();
    run_pair(0, 0, 0, 0, 1, 5, 0, 8, "R9 command beside load uses old");
    run_pair(1, 0, 0, 0, 0, 0, 0, 0, "R9 new settings used after");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_read();
    test_write();
    test_overlap();
    test_illegal();
    test_busy_ignore();
    test_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule